// File: doc/BRIEF.md
# Vertical-First Output Port Allocator

This unit sits in the switching stage of a router in a three-dimensional mesh. It decides, each cycle, which output port each of a small set of candidate packets leaves on. Each candidate carries its destination coordinates, a hop count, the port it arrived on, a valid bit and a flag that marks it as coming from the router's stall buffer. The router's own coordinates, a mask of the output ports that exist, and a flag that says the stall buffer is full complete the inputs.

Candidates are served one after another in priority order. Each one takes a free port that brings it closer to its destination, trying the vertical direction first and then the in-layer directions. When no such port is left and the stall buffer cannot take the packet back, the packet is pushed out of any free port so that it is not lost. A packet that gets no port is flagged as stalled. Decisions are registered, and a granted packet leaves with its hop count raised by one.

Top module: `zxyRouteUnit`

## Requirements
- R1: While rstN is low, and after it, until the first captured inputs, every output is zero.
- R2: Inputs presented before a rising clock edge produce their decision on the outputs right after that edge and not earlier.
- R3: Port codes are 0 east (+X), 1 west (-X), 2 north (+Y), 3 south (-Y), 4 up (+Z), 5 down (-Z), 6 local. A packet granted without deflection leaves on a port that moves it one step closer on that axis; a packet whose destination equals the router coordinates leaves on port 6.
- R4: Among free productive ports, up or down is taken first, then east or west, then north or south.
- R5: A packet is never granted the port it arrived on (origin code as in R3), nor a port whose bit in portEnable is clear.
- R6: Candidates from the stall buffer (candFromBuf = 1) are served before new ones, whatever their hop counts.
- R7: Within the same class, the larger hop count is served first; equal hop counts go to the lower candidate index.
- R8: No two candidates are granted the same port in one decision.
- R9: When bufFull is 1 and a candidate finds no free productive port, it is granted the first free enabled port, other than its origin, in the order east, west, north, south, up, down (never local), with outDeflect set; with no such port it stalls.
- R10: A valid candidate that gets no port has outStall = 1, outGrant = 0 and outPort = 0; with bufFull = 0 no deflection takes place. An invalid candidate shows all outputs zero.
- R11: A granted candidate's outHop is its hop count plus one, held at the all-ones maximum; a stalled candidate's outHop equals its input hop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hereX | input | COORD_W | Router X coordinate |
| hereY | input | COORD_W | Router Y coordinate |
| hereZ | input | COORD_W | Router Z coordinate |
| portEnable | input | 7 | One bit per output port that exists, indexed by port code |
| bufFull | input | 1 | Stall buffer cannot accept another packet |
| candValid | input | NUM_CAND | Candidate present |
| candFromBuf | input | NUM_CAND | Candidate comes from the stall buffer |
| candDestX | input | NUM_CAND x COORD_W | Destination X per candidate |
| candDestY | input | NUM_CAND x COORD_W | Destination Y per candidate |
| candDestZ | input | NUM_CAND x COORD_W | Destination Z per candidate |
| candHop | input | NUM_CAND x HOP_W | Hop count per candidate |
| candOrigin | input | NUM_CAND x 3 | Arrival port code per candidate |
| outGrant | output | NUM_CAND | Candidate was given a port |
| outDeflect | output | NUM_CAND | The given port is not productive (forced) |
| outStall | output | NUM_CAND | Candidate got no port |
| outPort | output | NUM_CAND x 3 | Chosen port code |
| outHop | output | NUM_CAND x HOP_W | Updated hop count |

## Verification
The allocator is driven with sets of four candidates that each stress one ordering: spread destinations that need no arbitration show the vertical-before-horizontal-before-lateral choice and local delivery, a shared vertical target shows fallback to the next productive axis, and pairs aimed at one port separate buffer precedence from hop-count ranking and index tie-breaking. Disabled ports and origin exclusion are tried with the buffer not full, giving stalls, and again with it full, where the deflection scan order and its exhaustion show up. A saturated hop count and an idle set close the sequence.

// File: rtl/zxyRoutePkg.sv
package zxyRoutePkg;
  localparam int PORT_CNT = 7;
  localparam int PORT_W   = 3;

  localparam logic [PORT_W-1:0] P_EAST  = 3'd0;
  localparam logic [PORT_W-1:0] P_WEST  = 3'd1;
  localparam logic [PORT_W-1:0] P_NORTH = 3'd2;
  localparam logic [PORT_W-1:0] P_SOUTH = 3'd3;
  localparam logic [PORT_W-1:0] P_UP    = 3'd4;
  localparam logic [PORT_W-1:0] P_DOWN  = 3'd5;
  localparam logic [PORT_W-1:0] P_LOCAL = 3'd6;

  // Ports a forced packet may be pushed to (all link ports, never local)
  localparam logic [PORT_CNT-1:0] LINK_PORTS = 7'b0111111;

  // Strobes from the allocation control to the datapath, one set per candidate
  typedef struct packed {
    logic              grant;
    logic              deflect;
    logic              stall;
    logic [PORT_W-1:0] port;
  } candDecisionT;
endpackage

// File: rtl/zxyDirCalc.sv
module zxyDirCalc
  import zxyRoutePkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0]  hereX,
  input  logic [COORD_W-1:0]  hereY,
  input  logic [COORD_W-1:0]  hereZ,
  input  logic [COORD_W-1:0]  destX,
  input  logic [COORD_W-1:0]  destY,
  input  logic [COORD_W-1:0]  destZ,
  output logic [PORT_CNT-1:0] prodMask
);
  always_comb begin
    prodMask          = '0;
    prodMask[P_EAST]  = destX > hereX;
    prodMask[P_WEST]  = destX < hereX;
    prodMask[P_NORTH] = destY > hereY;
    prodMask[P_SOUTH] = destY < hereY;
    prodMask[P_UP]    = destZ > hereZ;
    prodMask[P_DOWN]  = destZ < hereZ;
    prodMask[P_LOCAL] = (destX == hereX) && (destY == hereY) && (destZ == hereZ);
  end
endmodule

// File: rtl/zxyRouteCtrl.sv
module zxyRouteCtrl
  import zxyRoutePkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int HOP_W    = 4
) (
  input  logic [NUM_CAND-1:0]                candValid,
  input  logic [NUM_CAND-1:0]                candFromBuf,
  input  logic [NUM_CAND-1:0][HOP_W-1:0]     candHop,
  input  logic [NUM_CAND-1:0][PORT_W-1:0]    candOrigin,
  input  logic [NUM_CAND-1:0][PORT_CNT-1:0]  prodMask,
  input  logic [PORT_CNT-1:0]                portEnable,
  input  logic                               bufFull,
  output candDecisionT [NUM_CAND-1:0]        decision
);
  localparam int IDX_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;

  logic [NUM_CAND-1:0][IDX_W-1:0] rank;
  logic [NUM_CAND-1:0][IDX_W-1:0] ordIdx;
  logic [NUM_CAND-1:0]            ordValid;

  // j is served before i: buffer class, then hop count, then lower index
  function automatic logic servedFirst(input logic fbJ, input logic [HOP_W-1:0] hopJ,
                                       input logic fbI, input logic [HOP_W-1:0] hopI,
                                       input logic jLower);
    if (fbJ != fbI) return fbJ;
    if (hopJ != hopI) return hopJ > hopI;
    return jLower;
  endfunction

  always_comb begin
    rank = '0;
    for (int i = 0; i < NUM_CAND; i++) begin
      for (int j = 0; j < NUM_CAND; j++) begin
        if (j != i && candValid[j] &&
            servedFirst(candFromBuf[j], candHop[j], candFromBuf[i], candHop[i], j < i))
          rank[i] = rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    ordIdx   = '0;
    ordValid = '0;
    for (int r = 0; r < NUM_CAND; r++) begin
      for (int i = 0; i < NUM_CAND; i++) begin
        if (candValid[i] && rank[i] == IDX_W'(r)) begin
          ordValid[r] = 1'b1;
          ordIdx[r]   = IDX_W'(i);
        end
      end
    end
  end

  logic [PORT_CNT-1:0] occ;
  logic [PORT_CNT-1:0] originBit;
  logic [PORT_CNT-1:0] avail;
  logic [PORT_CNT-1:0] spill;
  logic [IDX_W-1:0]    cur;
  logic                found;
  logic                forced;
  logic [PORT_W-1:0]   pick;

  always_comb begin
    decision  = '0;
    occ       = '0;
    originBit = '0;
    avail     = '0;
    spill     = '0;
    cur       = '0;
    found     = 1'b0;
    forced    = 1'b0;
    pick      = '0;
    for (int r = 0; r < NUM_CAND; r++) begin
      if (ordValid[r]) begin
        cur       = ordIdx[r];
        originBit = PORT_CNT'(1) << candOrigin[cur];
        avail     = prodMask[cur] & portEnable & ~occ & ~originBit;
        found     = 1'b1;
        forced    = 1'b0;
        pick      = '0;
        if      (avail[P_UP])    pick = P_UP;
        else if (avail[P_DOWN])  pick = P_DOWN;
        else if (avail[P_EAST])  pick = P_EAST;
        else if (avail[P_WEST])  pick = P_WEST;
        else if (avail[P_NORTH]) pick = P_NORTH;
        else if (avail[P_SOUTH]) pick = P_SOUTH;
        else if (avail[P_LOCAL]) pick = P_LOCAL;
        else                     found = 1'b0;
        if (!found && bufFull) begin
          spill = portEnable & ~occ & ~originBit & LINK_PORTS;
          for (int k = 0; k < PORT_CNT; k++) begin
            if (!found && spill[k]) begin
              found  = 1'b1;
              forced = 1'b1;
              pick   = PORT_W'(k);
            end
          end
        end
        if (found) begin
          occ                  = occ | (PORT_CNT'(1) << pick);
          decision[cur].grant   = 1'b1;
          decision[cur].deflect = forced;
          decision[cur].port    = pick;
        end else begin
          decision[cur].stall = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/zxyRouteDatapath.sv
module zxyRouteDatapath
  import zxyRoutePkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int COORD_W  = 3,
  parameter int HOP_W    = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [COORD_W-1:0]                 hereX,
  input  logic [COORD_W-1:0]                 hereY,
  input  logic [COORD_W-1:0]                 hereZ,
  input  logic [NUM_CAND-1:0]                candValid,
  input  logic [NUM_CAND-1:0][COORD_W-1:0]   candDestX,
  input  logic [NUM_CAND-1:0][COORD_W-1:0]   candDestY,
  input  logic [NUM_CAND-1:0][COORD_W-1:0]   candDestZ,
  input  logic [NUM_CAND-1:0][HOP_W-1:0]     candHop,
  input  candDecisionT [NUM_CAND-1:0]        decision,
  output logic [NUM_CAND-1:0][PORT_CNT-1:0]  prodMask,
  output logic [NUM_CAND-1:0]                outGrant,
  output logic [NUM_CAND-1:0]                outDeflect,
  output logic [NUM_CAND-1:0]                outStall,
  output logic [NUM_CAND-1:0][PORT_W-1:0]    outPort,
  output logic [NUM_CAND-1:0][HOP_W-1:0]     outHop
);
  localparam logic [HOP_W-1:0] HOP_MAX = {HOP_W{1'b1}};

  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
    logic [HOP_W-1:0] hopNext;

    zxyDirCalc #(.COORD_W(COORD_W)) i_dir (
      .hereX   (hereX),
      .hereY   (hereY),
      .hereZ   (hereZ),
      .destX   (candDestX[c]),
      .destY   (candDestY[c]),
      .destZ   (candDestZ[c]),
      .prodMask(prodMask[c])
    );

    always_comb begin
      if (!candValid[c])                      hopNext = '0;
      else if (!decision[c].grant)            hopNext = candHop[c];
      else if (candHop[c] == HOP_MAX)         hopNext = HOP_MAX;
      else                                    hopNext = candHop[c] + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outGrant[c]   <= 1'b0;
        outDeflect[c] <= 1'b0;
        outStall[c]   <= 1'b0;
        outPort[c]    <= '0;
        outHop[c]     <= '0;
      end else begin
        outGrant[c]   <= decision[c].grant;
        outDeflect[c] <= decision[c].deflect;
        outStall[c]   <= decision[c].stall;
        outPort[c]    <= decision[c].port;
        outHop[c]     <= hopNext;
      end
    end
  end
endmodule

// File: rtl/zxyRouteUnit.sv
module zxyRouteUnit
  import zxyRoutePkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int COORD_W  = 3,
  parameter int HOP_W    = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [COORD_W-1:0]                hereX,
  input  logic [COORD_W-1:0]                hereY,
  input  logic [COORD_W-1:0]                hereZ,
  input  logic [6:0]                        portEnable,
  input  logic                              bufFull,
  input  logic [NUM_CAND-1:0]               candValid,
  input  logic [NUM_CAND-1:0]               candFromBuf,
  input  logic [NUM_CAND-1:0][COORD_W-1:0]  candDestX,
  input  logic [NUM_CAND-1:0][COORD_W-1:0]  candDestY,
  input  logic [NUM_CAND-1:0][COORD_W-1:0]  candDestZ,
  input  logic [NUM_CAND-1:0][HOP_W-1:0]    candHop,
  input  logic [NUM_CAND-1:0][2:0]          candOrigin,
  output logic [NUM_CAND-1:0]               outGrant,
  output logic [NUM_CAND-1:0]               outDeflect,
  output logic [NUM_CAND-1:0]               outStall,
  output logic [NUM_CAND-1:0][2:0]          outPort,
  output logic [NUM_CAND-1:0][HOP_W-1:0]    outHop
);
  logic [NUM_CAND-1:0][PORT_CNT-1:0] prodMask;
  candDecisionT [NUM_CAND-1:0]       decision;

  zxyRouteCtrl #(.NUM_CAND(NUM_CAND), .HOP_W(HOP_W)) i_ctrl (
    .candValid  (candValid),
    .candFromBuf(candFromBuf),
    .candHop    (candHop),
    .candOrigin (candOrigin),
    .prodMask   (prodMask),
    .portEnable (portEnable),
    .bufFull    (bufFull),
    .decision   (decision)
  );

  zxyRouteDatapath #(.NUM_CAND(NUM_CAND), .COORD_W(COORD_W), .HOP_W(HOP_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hereX     (hereX),
    .hereY     (hereY),
    .hereZ     (hereZ),
    .candValid (candValid),
    .candDestX (candDestX),
    .candDestY (candDestY),
    .candDestZ (candDestZ),
    .candHop   (candHop),
    .decision  (decision),
    .prodMask  (prodMask),
    .outGrant  (outGrant),
    .outDeflect(outDeflect),
    .outStall  (outStall),
    .outPort   (outPort),
    .outHop    (outHop)
  );
endmodule

// File: rtl/zxyRouteChecker.sv
module zxyRouteChecker #(
  parameter int NUM_CAND = 4,
  parameter int HOP_W    = 4
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [6:0]                      portEnable,
  input logic                            bufFull,
  input logic [NUM_CAND-1:0]             candValid,
  input logic [NUM_CAND-1:0][HOP_W-1:0]  candHop,
  input logic [NUM_CAND-1:0][2:0]        candOrigin,
  input logic [NUM_CAND-1:0]             outGrant,
  input logic [NUM_CAND-1:0]             outDeflect,
  input logic [NUM_CAND-1:0]             outStall,
  input logic [NUM_CAND-1:0][2:0]        outPort,
  input logic [NUM_CAND-1:0][HOP_W-1:0]  outHop
);
  for (genvar i = 0; i < NUM_CAND; i++) begin : g_one
    p_not_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && outGrant[i]) |-> (outPort[i] != $past(candOrigin[i])));

    p_port_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && outGrant[i]) |-> ((($past(portEnable) >> outPort[i]) & 7'd1) != 7'd0));

    p_deflect_full_r9: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && outDeflect[i]) |-> ($past(bufFull) && outGrant[i]));

    p_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (($past(candValid[i]) ? 1 : 0) == $countones({outGrant[i], outStall[i]})));

    p_hop_step_r11: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && outGrant[i]) |->
        (outHop[i] == (($past(candHop[i]) == {HOP_W{1'b1}}) ? {HOP_W{1'b1}}
                                                          : HOP_W'($past(candHop[i]) + 1'b1))));

    for (genvar j = i + 1; j < NUM_CAND; j++) begin : g_pair
      p_port_unique_r8: assert property (@(posedge clk) disable iff (!rstN)
        (outGrant[i] && outGrant[j]) |-> (outPort[i] != outPort[j]));
    end
  end
endmodule

bind zxyRouteUnit zxyRouteChecker #(.NUM_CAND(NUM_CAND), .HOP_W(HOP_W)) i_chk (.*);

// File: tb/test_zxyRouteUnit.sv
module test_zxyRouteUnit;
  localparam int NC = 4;
  localparam int CW = 3;
  localparam int HW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] hereX = 3'd2, hereY = 3'd2, hereZ = 3'd2;
  logic [6:0] portEnable = '0;
  logic bufFull = 1'b0;
  logic [NC-1:0] candValid = '0, candFromBuf = '0;
  logic [NC-1:0][CW-1:0] candDestX = '0, candDestY = '0, candDestZ = '0;
  logic [NC-1:0][HW-1:0] candHop = '0;
  logic [NC-1:0][2:0] candOrigin = '0;
  logic [NC-1:0] outGrant, outDeflect, outStall;
  logic [NC-1:0][2:0] outPort;
  logic [NC-1:0][HW-1:0] outHop;

  always #5 clk = ~clk;

  zxyRouteUnit #(.NUM_CAND(NC), .COORD_W(CW), .HOP_W(HW)) i_zxyRouteUnit (.*);

  // staged stimulus and expectation
  logic [6:0] sEn;
  logic sFull;
  logic [NC-1:0] sValid, sBuf;
  logic [NC-1:0][CW-1:0] sX, sY, sZ;
  logic [NC-1:0][HW-1:0] sHop;
  logic [NC-1:0][2:0] sOrig;

  typedef struct {
    string tag;
    logic [NC-1:0] g, d, s;
    logic [NC-1:0][2:0] p;
    logic [NC-1:0][HW-1:0] h;
  } expT;

  expT eCur;
  expT q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic clearStage(input logic [6:0] en, input logic full, input string tag);
    sEn = en; sFull = full; sValid = '0; sBuf = '0;
    sX = '0; sY = '0; sZ = '0; sHop = '0; sOrig = '0;
    eCur.tag = tag; eCur.g = '0; eCur.d = '0; eCur.s = '0; eCur.p = '0; eCur.h = '0;
  endtask

  task automatic cand(input int i, input logic fb, input int x, input int y, input int z,
                      input int hop, input int orig);
    sValid[i] = 1'b1; sBuf[i] = fb;
    sX[i] = CW'(x); sY[i] = CW'(y); sZ[i] = CW'(z);
    sHop[i] = HW'(hop); sOrig[i] = 3'(orig);
  endtask

  task automatic expect1(input int i, input logic g, input logic d, input logic s,
                         input int p, input int h);
    eCur.g[i] = g; eCur.d[i] = d; eCur.s[i] = s; eCur.p[i] = 3'(p); eCur.h[i] = HW'(h);
  endtask

  task automatic fire();
    @(negedge clk);
    portEnable = sEn; bufFull = sFull; candValid = sValid; candFromBuf = sBuf;
    candDestX = sX; candDestY = sY; candDestZ = sZ; candHop = sHop; candOrigin = sOrig;
    q.push_back(eCur);
  endtask

  // monitor: results of inputs captured at an edge are compared just after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        expT e;
        e = q.pop_front();
        for (int i = 0; i < NC; i++) begin
          checks++;
          if (outGrant[i] !== e.g[i] || outDeflect[i] !== e.d[i] || outStall[i] !== e.s[i] ||
              outPort[i] !== e.p[i] || outHop[i] !== e.h[i]) begin
            fails++;
            $display("FAIL %s cand%0d g/d/s/port/hop actual %b%b%b/%0d/%0d expected %b%b%b/%0d/%0d",
                     e.tag, i, outGrant[i], outDeflect[i], outStall[i], outPort[i], outHop[i],
                     e.g[i], e.d[i], e.s[i], e.p[i], e.h[i]);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 reset state
    if (outGrant !== '0 || outDeflect !== '0 || outStall !== '0 || outPort !== '0 || outHop !== '0) begin
      fails++;
      $display("FAIL R1 outputs in reset actual %b %b %b expected all zero", outGrant, outStall, outPort);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R3 R4 R11: distinct productive axes, local delivery, all arrived from west
    clearStage(7'h7F, 1'b0, "R3/R4/R11 spread");
    cand(0, 0, 3, 3, 3, 1, 1); expect1(0, 1, 0, 0, 4, 2);
    cand(1, 0, 3, 3, 2, 1, 1); expect1(1, 1, 0, 0, 0, 2);
    cand(2, 0, 2, 1, 2, 1, 1); expect1(2, 1, 0, 0, 3, 2);
    cand(3, 0, 2, 2, 2, 1, 1); expect1(3, 1, 0, 0, 6, 2);
    fire();
    #1;
    checks++;  // R2 nothing appears before the capturing edge
    if (outGrant !== '0) begin
      fails++;
      $display("FAIL R2 early output actual %b expected 0", outGrant);
    end

    // R4 R6: buffered packet takes up, new one falls back to east; R10 idle slots zero
    clearStage(7'h7F, 1'b0, "R4/R6/R10 vertical taken");
    cand(0, 1, 2, 2, 3, 5, 6); expect1(0, 1, 0, 0, 4, 6);
    cand(1, 0, 3, 2, 3, 1, 6); expect1(1, 1, 0, 0, 0, 2);
    fire();

    // R6 R10: buffered low-hop beats new high-hop for down, loser stalls
    clearStage(7'h7F, 1'b0, "R6/R10 buffer first");
    cand(0, 0, 2, 2, 1, 9, 6); expect1(0, 0, 0, 1, 0, 9);
    cand(1, 1, 2, 2, 1, 1, 6); expect1(1, 1, 0, 0, 5, 2);
    fire();

    // R7: larger hop wins west, equal hops go to lower index for north
    clearStage(7'h7F, 1'b0, "R7 hop order");
    cand(0, 0, 1, 2, 2, 3, 6); expect1(0, 0, 0, 1, 0, 3);
    cand(1, 0, 1, 2, 2, 7, 6); expect1(1, 1, 0, 0, 1, 8);
    cand(2, 0, 2, 3, 2, 4, 6); expect1(2, 1, 0, 0, 2, 5);
    cand(3, 0, 2, 3, 2, 4, 6); expect1(3, 0, 0, 1, 0, 4);
    fire();

    // R5 R10: origin excluded, disabled up port, buffer not full
    clearStage(7'b1101111, 1'b0, "R5/R10 excluded ports");
    cand(0, 0, 3, 2, 2, 0, 0); expect1(0, 0, 0, 1, 0, 0);
    cand(1, 0, 2, 2, 3, 0, 6); expect1(1, 0, 0, 1, 0, 0);
    cand(2, 0, 3, 3, 2, 0, 0); expect1(2, 1, 0, 0, 2, 1);
    fire();

    // R9: deflection in east, west, north order skipping origin and taken ports
    clearStage(7'b1101111, 1'b1, "R9 deflect order");
    cand(0, 0, 2, 2, 3, 2, 0); expect1(0, 1, 1, 0, 1, 3);
    cand(1, 0, 2, 2, 3, 1, 6); expect1(1, 1, 1, 0, 0, 2);
    cand(2, 0, 1, 2, 2, 0, 6); expect1(2, 1, 1, 0, 2, 1);
    fire();

    // R9 R11: deflect scan exhausted, saturated hop, productive grants not flagged
    clearStage(7'b0000011, 1'b1, "R9/R11 exhausted");
    cand(0, 0, 3, 2, 2, 3, 6);  expect1(0, 1, 0, 0, 0, 4);
    cand(1, 0, 3, 2, 2, 2, 6);  expect1(1, 0, 0, 1, 0, 2);
    cand(2, 0, 3, 2, 2, 1, 6);  expect1(2, 0, 0, 1, 0, 1);
    cand(3, 0, 1, 2, 2, 15, 6); expect1(3, 1, 0, 0, 1, 15);
    fire();

    // R10: no candidates gives all-zero outputs
    clearStage(7'h7F, 1'b1, "R10 idle");
    fire();

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule